// File: doc/BRIEF.md
# Eight-Bit Bidirectional GPIO Port

This block is one general-purpose I/O port of a small microcontroller. Software reaches it through a plain register bus with a write strobe, a 2-bit address, write data and a combinational read-data output. Three registers hold the port state: an output latch, a direction mask and an analog-select mask. The block sends a value and an output enable for every pin to the pad ring. It passes pin inputs through a two-flop synchronizer and returns them when the port address is read.

Two controls override the plain latch and direction behaviour on single pins. When a pin's analog-select bit is set, its digital input is hidden from software, but the pin can still be driven as an output. When the oscillator-mode input is set, the two top pins belong to the oscillator and lose all digital function. In that mode, if the clock-out enable is also set, pin 6 carries the instruction-cycle clock, which is the block clock divided by four. Two raw pin values are also sent straight to peripheral clock and gate inputs.

Top module: `gpio_port`

## Requirements
- R1: Reset values are as follows. Direction reads 0xFF, so every pin is an input. The latch reads 0x00 and analog select reads 0x2F. Every pad_oe_o bit is 0. Register addresses: 0 = port, 1 = latch, 2 = direction, 3 = analog select.
- R2: A direction bit of 0 sets pad_oe_o for that pin to 1 and drives pad_out_o from the latch bit. A direction bit of 1 sets pad_oe_o to 0.
- R3: A write to address 0 or to address 1 loads the latch at the next clock edge. Reading address 1 returns the latch contents, not the pin states.
- R4: Reading address 0 returns the pin states after a two-flop synchronizer. A pad_in_i change set up before clock edge k is not visible after edge k. It is visible after edge k+1.
- R5: A pin whose analog-select bit is 1 reads as 0 at address 0. Its output drive and output enable are unchanged.
- R6: With osc_mode_i = 1, pins 6 and 7 read as 0 at address 0 and have pad_oe_o = 0, whatever the direction bits say. The only exception is the case given in R7.
- R7: With osc_mode_i = 1 and clkout_en_i = 1, pin 6 is driven with pad_oe_o[6] = 1. Its pad_out_o[6] is a square wave with a period of four clocks, high for two clocks and low for two. Pin 7 stays undriven.
- R8: periph_clk_a_o follows pad_in_i[4], periph_clk_b_o follows pad_in_i[5] and periph_gate_o follows pad_in_i[5]. These outputs are combinational and do not depend on direction or analog select.
- R9: Writes to addresses 2 and 3 load the direction and analog-select registers at the next edge. Each register reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| osc_mode_i | input | 1 | Gives pins 6 and 7 to the oscillator |
| clkout_en_i | input | 1 | Puts the cycle clock on pin 6 in oscillator mode |
| pad_in_i | input | 8 | Raw pin levels from the pads |
| pad_out_o | output | 8 | Pin output values |
| pad_oe_o | output | 8 | Pin output enables |
| periph_clk_a_o | output | 1 | Raw pin 4 to a timer clock input |
| periph_clk_b_o | output | 1 | Raw pin 5 to a timer clock input |
| periph_gate_o | output | 1 | Raw pin 5 to a timer gate input |

## Verification
The bench samples the port read one edge and then two edges after a pin change. A design with a single synchronizer stage or no synchronizer would show the new value too early. It sets analog-select bits on pins that are outputs and checks that the drive stays on. A design that masked the output path along with the input would drop the pin. It turns on oscillator mode with pins 6 and 7 set as outputs and checks that they float and read 0, and that a pin 6 clock has a period of four edges. A divider of the wrong length, or an override missed on one of the two pins, shows up as a mismatch.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    REG_PORT = 2'd0,
    REG_LAT  = 2'd1,
    REG_DIR  = 2'd2,
    REG_ANA  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] DIR_RST = '1,
  parameter logic [W-1:0] ANA_RST = 8'h2F
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] lat_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] ana_o
);
  // port address writes land in the latch so read-modify-write uses latch data
  logic lat_we, dir_we, ana_we;
  assign lat_we = wr_en_i && (addr_i == REG_PORT || addr_i == REG_LAT);
  assign dir_we = wr_en_i && (addr_i == REG_DIR);
  assign ana_we = wr_en_i && (addr_i == REG_ANA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_o <= '0;
      dir_o <= DIR_RST;
      ana_o <= ANA_RST;
    end else begin
      if (lat_we) lat_o <= wdata_i;
      if (dir_we) dir_o <= wdata_i;
      if (ana_we) ana_o <= wdata_i;
    end
  end

  assert_latch_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == REG_PORT || addr_i == REG_LAT)) |=> (lat_o == $past(wdata_i)));
  assert_dir_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_DIR) |=> (dir_o == $past(wdata_i)));
  assert_ana_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_ANA) |=> (ana_o == $past(wdata_i)));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else         chain_q[s] <= (s == 0) ? d_i : chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] age_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         age_q <= '0;
      else if (age_q != 2) age_q <= age_q + 2'd1;
    end
    assert_sync_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2) |-> (q_o == $past(d_i, 2)));
  end
endmodule

// File: rtl/gpio_clkdiv.sv
module gpio_clkdiv #(
  parameter int unsigned DIV_LOG2 = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic cyc_clk_o
);
  logic [DIV_LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cyc_clk_o = cnt_q[DIV_LOG2-1];

  assert_clk_high_two_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cyc_clk_o) |=> $stable(cyc_clk_o));
  assert_clk_low_two_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cyc_clk_o) |=> $stable(cyc_clk_o));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned SYNC_STG = 2,
  parameter int unsigned DIV_LOG2 = 2,
  parameter logic [W-1:0] DIR_RST = '1,
  parameter logic [W-1:0] ANA_RST = 8'h2F,
  parameter int unsigned CLKA_PIN = 4,
  parameter int unsigned CLKB_PIN = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic         osc_mode_i,
  input  logic         clkout_en_i,
  input  logic [W-1:0] pad_in_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  output logic         periph_clk_a_o,
  output logic         periph_clk_b_o,
  output logic         periph_gate_o
);
  localparam int unsigned CLKO_PIN = W - 2;
  localparam logic [W-1:0] OSC_PINS = {2'b11, {(W-2){1'b0}}};

  logic [W-1:0] lat_q, dir_q, ana_q, sync_q, osc_own, din_vis;
  logic cyc_clk, clkout_on;

  gpio_regs #(.W(W), .DIR_RST(DIR_RST), .ANA_RST(ANA_RST)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .lat_o(lat_q), .dir_o(dir_q), .ana_o(ana_q)
  );

  gpio_sync #(.W(W), .STAGES(SYNC_STG)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(sync_q)
  );

  gpio_clkdiv #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk_i, .rst_ni, .cyc_clk_o(cyc_clk)
  );

  assign osc_own   = osc_mode_i ? OSC_PINS : '0;
  assign clkout_on = osc_mode_i && clkout_en_i;

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (i == CLKO_PIN) begin : g_clko
      assign pad_oe_o[i]  = clkout_on ? 1'b1 : (!osc_own[i] && !dir_q[i]);
      assign pad_out_o[i] = clkout_on ? cyc_clk : (!osc_own[i] && lat_q[i]);
    end else begin : g_plain
      assign pad_oe_o[i]  = !osc_own[i] && !dir_q[i];
      assign pad_out_o[i] = !osc_own[i] && lat_q[i];
    end
    // analog select hides only the digital input
    assign din_vis[i] = sync_q[i] && !ana_q[i] && !osc_own[i];
  end

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      REG_PORT: rdata_o = din_vis;
      REG_LAT:  rdata_o = lat_q;
      REG_DIR:  rdata_o = dir_q;
      default:  rdata_o = ana_q;
    endcase
  end

  assign periph_clk_a_o = pad_in_i[CLKA_PIN];
  assign periph_clk_b_o = pad_in_i[CLKB_PIN];
  assign periph_gate_o  = pad_in_i[CLKB_PIN];

  assert_masked_read_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_PORT) |-> ((rdata_o & (ana_q | osc_own)) == '0));
  assert_osc_pin7_float_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_mode_i |-> !pad_oe_o[W-1]);
  assert_output_follows_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_mode_i |-> ((pad_out_o & pad_oe_o) == (lat_q & ~dir_q)));
  assert_clkout_driven_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clkout_on |-> pad_oe_o[CLKO_PIN]);
endmodule

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic osc_mode = 1'b0;
  logic clkout_en = 1'b0;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_out, pad_oe;
  logic pca, pcb, pgate;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  gpio_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .osc_mode_i(osc_mode), .clkout_en_i(clkout_en),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .periph_clk_a_o(pca), .periph_clk_b_o(pcb), .periph_gate_o(pgate)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd2, v); check("R1 dir", v, 8'hFF);
    rd(2'd1, v); check("R1 latch", v, 8'h00);
    rd(2'd3, v); check("R1 analog", v, 8'h2F);
    check("R1 oe", pad_oe, 8'h00);
  endtask

  task automatic t_reg_rw;
    logic [7:0] v;
    wr(2'd2, 8'hA5); rd(2'd2, v); check("R9 dir rw", v, 8'hA5);
    wr(2'd3, 8'h5A); rd(2'd3, v); check("R9 ana rw", v, 8'h5A);
    wr(2'd3, 8'h00); wr(2'd2, 8'hFF);
  endtask

  task automatic t_output_drive;
    wr(2'd1, 8'b1010_0110);
    wr(2'd2, 8'b1111_0000);
    #1;
    check("R2 oe", pad_oe, 8'b0000_1111);
    check("R2 out", pad_out & pad_oe, 8'b0000_0110);
    wr(2'd2, 8'hFF);
    #1 check("R2 all input", pad_oe, 8'h00);
  endtask

  task automatic t_latch_rmw;
    logic [7:0] v;
    pad_in = 8'hFF;
    repeat (3) @(negedge clk);
    wr(2'd0, 8'h3C);
    rd(2'd1, v); check("R3 port write to latch", v, 8'h3C);
    rd(2'd0, v); check("R3 port read shows pins", v, 8'hFF);
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    rd(2'd1, v); check("R3 latch independent of pins", v, 8'h3C);
  endtask

  task automatic t_sync_latency;
    logic [7:0] v;
    pad_in = 8'h00; addr = 2'd0;
    repeat (3) @(negedge clk);
    pad_in = 8'h96;
    @(negedge clk); rd(2'd0, v); check("R4 one edge", v, 8'h00);
    @(negedge clk); rd(2'd0, v); check("R4 two edges", v, 8'h96);
  endtask

  task automatic t_analog_mask;
    logic [7:0] v;
    wr(2'd1, 8'h0F);
    wr(2'd2, 8'hF0);
    pad_in = 8'hFF;
    wr(2'd3, 8'h0F);
    repeat (2) @(negedge clk);
    rd(2'd0, v); check("R5 masked read", v, 8'hF0);
    check("R5 drive kept oe", pad_oe, 8'h0F);
    check("R5 drive kept out", pad_out, 8'h0F);
    wr(2'd3, 8'h00); wr(2'd2, 8'hFF);
  endtask

  task automatic t_osc_mode;
    logic [7:0] v;
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h00);
    pad_in = 8'hFF;
    @(negedge clk);
    osc_mode = 1'b1; clkout_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 oe", pad_oe, 8'h3F);
    rd(2'd0, v); check("R6 read", v, 8'h3F);
    rd(2'd2, v); check("R6 dir unchanged", v, 8'h00);
  endtask

  task automatic t_clkout;
    logic s [8];
    clkout_en = 1'b1;
    @(negedge clk);
    check("R7 pin6 driven", {6'd0, pad_oe[7:6]}, 8'h01);
    for (int n = 0; n < 8; n++) begin
      #1 s[n] = pad_out[6];
      @(negedge clk);
    end
    for (int n = 0; n < 6; n++)
      check("R7 period four", {7'd0, s[n+2]}, {7'd0, ~s[n]});
    check("R7 duty", {7'd0, s[0] ^ s[1] ^ s[2] ^ s[3]}, 8'h00);
    osc_mode = 1'b0; clkout_en = 1'b0;
    wr(2'd2, 8'hFF);
  endtask

  task automatic t_periph;
    wr(2'd2, 8'h00);
    wr(2'd3, 8'hFF);
    pad_in = 8'b0001_0000;
    #1 check("R8 raw pins 4/5", {5'd0, pca, pcb, pgate}, 8'b0000_0100);
    pad_in = 8'b0010_0000;
    #1 check("R8 raw pins 4/5 b", {5'd0, pca, pcb, pgate}, 8'b0000_0011);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reg_rw();
    t_output_drive();
    t_latch_rmw();
    t_sync_latency();
    t_analog_mask();
    t_osc_mode();
    t_clkout();
    t_periph();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule